// File: doc/BRIEF.md
# Four-Channel Compare Timer with Watchdog Reset

This block is an operating-system timer for a processor subsystem. A single 32-bit up-counter advances once for every cycle in which an external prescaler pulses `tick_i`. Four 32-bit compare registers sit beside the counter. When a tick brings the counter onto a compare value, the block can latch a sticky event bit for that channel and drive that channel's interrupt line. Whether it does so depends on the interrupt mask.

Software reaches the block over a small synchronous register bus. Writes take effect on the clock edge. Read data and the bad-address flag are registered and appear one cycle after the read strobe. Compare channel 3 has a second role as a one-shot watchdog. If software arms it and the counter reaches compare value 3, the block emits a one-cycle reset request and disarms itself.

The watchdog is a three-state machine:
- `WD_IDLE` goes to `WD_ARMED` on a write of 1 to bit 0 of the watchdog register ("arm").
- `WD_ARMED` goes back to `WD_IDLE` on a write of 0 ("disarm").
- `WD_ARMED` goes to `WD_FIRE` on a channel 3 hit ("expire").
- `WD_FIRE` goes to `WD_IDLE` on the next clock ("return"), or to `WD_ARMED` if a write of 1 lands in that cycle.

Top module: `tmr4_os_timer`

Register offsets (byte addresses):
- 0x00, 0x04, 0x08 and 0x0C hold compare values 0 to 3.
- 0x10 is the counter.
- 0x14 is the event register. Bit i belongs to channel i.
- 0x18 is the watchdog register. Only bit 0 is used.
- 0x1C is the interrupt mask. Bit i enables channel i.

## Requirements
- R1: After reset every register reads 0, and `irq_o`, `rst_req_o` and `err_o` are all 0.
- R2: In each clock cycle with `tick_i`=1, the counter advances by one. It holds when `tick_i`=0, and after 0xFFFFFFFF it wraps to 0.
- R3: A write to offset 0x10 loads the counter, and counting continues from the loaded value. In a cycle that has both a load and a tick, the load wins. A load never counts as a compare hit.
- R4: A hit occurs when a tick brings the counter equal to compare value i while mask bit i is 1. Event bit i and `irq_o[i]` then rise on the clock after the cycle in which the counter first shows that value.
- R5: A hit on a channel whose mask bit is 0 records nothing. Setting the mask bit later does not raise that channel's event bit or interrupt.
- R6: A write to offset 0x14 clears every event bit whose data bit is 1 and leaves the others as they are. The interrupt falls on the next clock. If a new hit and a clear reach the same bit in the same cycle, the hit wins.
- R7: The mask register stores data bits 11:0 and discards the bits above them. It reads back zero-extended.
- R8: While the watchdog is armed, a channel 3 hit raises `rst_req_o` for exactly one cycle, on the same clock as event bit 3 would rise. This happens whatever mask bit 3 holds. Afterwards the watchdog register reads 0. Only bit 0 of a write is stored.
- R9: While the watchdog is disarmed, a channel 3 hit never raises `rst_req_o`.
- R10: A read returns the value of the addressed register on `rdata_o` one cycle after `re_i`.
- R11: A read from any other offset returns 0 and pulses `err_o` for that one cycle. A write to any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-enable pulse from the prescaler |
| addr_i | input | ADDR_W (8) | Byte offset of the register |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Registered read data |
| irq_o | output | 4 | Interrupt line for each channel |
| rst_req_o | output | 1 | One-cycle system reset request |
| err_o | output | 1 | One-cycle flag for a read from an undefined offset |

## Verification
The timing chain is as follows:
- A tick at clock edge E0 puts the compare value on the counter.
- The hit is evaluated during the cycle that follows.
- The event bit, the interrupt and any reset request all become visible after edge E1.
- The reset request is gone again after edge E2.

An event clear lands at the edge of the write, and the interrupt is low right after that edge. Read data and `err_o` appear one edge after the strobe.

The bench changes inputs on falling edges and samples outputs on the falling edge after the edge in question. To catch an event one cycle early, it checks each interrupt both at the sample point just after the counter reaches the compare value and one sample later. The set-versus-clear collision is exercised by placing the event-register write on exactly edge E1.

// File: rtl/tmr4_pkg.sv
package tmr4_pkg;
    localparam int NUM_CH = 4;
    localparam int WD_CH  = 3;

    localparam int OFS_CMP0 = 'h00;
    localparam int OFS_CNT  = 'h10;
    localparam int OFS_EVT  = 'h14;
    localparam int OFS_WDG  = 'h18;
    localparam int OFS_MASK = 'h1C;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_e;
endpackage

// File: rtl/tmr4_counter.sv
module tmr4_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          ld_i,
    input  logic [CW-1:0] ld_val_i,
    output logic [CW-1:0] cnt_o,
    output logic          adv_o
);
    logic [CW-1:0] cnt_q;
    logic          adv_q;

    // A load beats a tick and clears the advance flag, so a load never produces a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            adv_q <= 1'b0;
        end else if (ld_i) begin
            cnt_q <= ld_val_i;
            adv_q <= 1'b0;
        end else begin
            if (tick_i) cnt_q <= cnt_q + 1'b1;
            adv_q <= tick_i;
        end
    end

    assign cnt_o = cnt_q;
    assign adv_o = adv_q;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !ld_i) |=> cnt_q == $past(cnt_q) + 1'b1);
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !ld_i) |=> $stable(cnt_q));
    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (cnt_q == $past(ld_val_i)) && !adv_q);
endmodule

// File: rtl/tmr4_chan.sv
module tmr4_chan #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cmp_i,
    input  logic [CW-1:0] wdata_i,
    input  logic          adv_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          en_i,
    input  logic          clr_i,
    output logic [CW-1:0] cmp_o,
    output logic          hit_o,
    output logic          evt_o
);
    logic [CW-1:0] cmp_q;
    logic          evt_q;
    logic          hit;

    assign hit = adv_i && (cnt_i == cmp_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            evt_q <= 1'b0;
        end else begin
            if (wr_cmp_i) cmp_q <= wdata_i;
            if (hit && en_i)  evt_q <= 1'b1;
            else if (clr_i)   evt_q <= 1'b0;
        end
    end

    assign cmp_o = cmp_q;
    assign hit_o = hit;
    assign evt_o = evt_q;

    assert_hit_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && en_i) |=> evt_q);
    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !evt_q) |=> !evt_q);
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(hit && en_i)) |=> !evt_q);
endmodule

// File: rtl/tmr4_wdog.sv
module tmr4_wdog
    import tmr4_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic arm_i,
    input  logic hit_i,
    output logic armed_o,
    output logic fire_o
);
    wd_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:  if (wr_i) state_d = arm_i ? WD_ARMED : WD_IDLE;
            WD_ARMED: begin
                if (hit_i)     state_d = WD_FIRE;
                else if (wr_i) state_d = arm_i ? WD_ARMED : WD_IDLE;
            end
            WD_FIRE:  state_d = (wr_i && arm_i) ? WD_ARMED : WD_IDLE;
            default:  state_d = WD_IDLE;
        endcase
    end

    always_comb begin
        armed_o = 1'b0;
        fire_o  = 1'b0;
        unique case (state_q)
            WD_IDLE:  ;
            WD_ARMED: armed_o = 1'b1;
            WD_FIRE:  fire_o  = 1'b1;
            default:  ;
        endcase
    end

    assert_fire_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_FIRE) |=> (state_q != WD_FIRE));
    assert_fire_from_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_FIRE) |-> ($past(state_q) == WD_ARMED));
    assert_idle_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_IDLE && !wr_i) |=> (state_q == WD_IDLE));
endmodule

// File: rtl/tmr4_os_timer.sv
module tmr4_os_timer
    import tmr4_pkg::*;
#(
    parameter int DW     = 32,
    parameter int ADDR_W = 8,
    parameter int MASK_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic [NUM_CH-1:0] irq_o,
    output logic              rst_req_o,
    output logic              err_o
);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
    localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(OFS_EVT);
    localparam logic [ADDR_W-1:0] A_WDG  = ADDR_W'(OFS_WDG);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

    logic [DW-1:0]     cnt;
    logic              adv;
    logic [DW-1:0]     cmp [NUM_CH];
    logic [NUM_CH-1:0] hit, evt;
    logic [MASK_W-1:0] mask_q;
    logic              armed, fire;
    logic [DW-1:0]     rd_mux;
    logic              rd_ok;
    logic [DW-1:0]     rdata_q;
    logic              err_q;

    tmr4_counter #(.CW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .ld_i(we_i && addr_i == A_CNT), .ld_val_i(wdata_i),
        .cnt_o(cnt), .adv_o(adv)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr4_chan #(.CW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_cmp_i(we_i && addr_i == ADDR_W'(OFS_CMP0 + 4 * i)),
            .wdata_i(wdata_i), .adv_i(adv), .cnt_i(cnt),
            .en_i(mask_q[i]),
            .clr_i(we_i && addr_i == A_EVT && wdata_i[i]),
            .cmp_o(cmp[i]), .hit_o(hit[i]), .evt_o(evt[i])
        );
    end

    tmr4_wdog u_wd (
        .clk(clk), .rst_n(rst_n),
        .wr_i(we_i && addr_i == A_WDG), .arm_i(wdata_i[0]),
        .hit_i(hit[WD_CH]), .armed_o(armed), .fire_o(fire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_q <= '0;
        else if (we_i && addr_i == A_MASK)   mask_q <= wdata_i[MASK_W-1:0];
    end

    always_comb begin
        rd_mux = '0;
        rd_ok  = 1'b1;
        unique case (addr_i)
            A_CNT:   rd_mux = cnt;
            A_EVT:   rd_mux = DW'(evt);
            A_WDG:   rd_mux = DW'(armed);
            A_MASK:  rd_mux = DW'(mask_q);
            default: begin
                rd_ok = 1'b0;
                for (int i = 0; i < NUM_CH; i++) begin
                    if (addr_i == ADDR_W'(OFS_CMP0 + 4 * i)) begin
                        rd_mux = cmp[i];
                        rd_ok  = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= re_i && !rd_ok;
            if (re_i) rdata_q <= rd_ok ? rd_mux : '0;
        end
    end

    assign rdata_o   = rdata_q;
    assign err_o     = err_q;
    assign irq_o     = evt;
    assign rst_req_o = fire;

    assert_err_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (rdata_o == '0));
    assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !re_i |=> !err_o);
    assert_req_clears_wd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !armed);
endmodule

// File: tb/tmr4_os_timer_tb.sv
module tmr4_os_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic        we_i = 1'b0;
    logic        re_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [3:0]  irq_o;
    logic        rst_req_o;
    logic        err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tmr4_os_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
        .we_i(we_i), .re_i(re_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .irq_o(irq_o), .rst_req_o(rst_req_o), .err_o(err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        addr_i = a; wdata_i = d; we_i = 1'b1;
        step();
        we_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic e);
        addr_i = a; re_i = 1'b1;
        step();
        re_i = 1'b0;
        d = rdata_o; e = err_o;
    endtask

    task automatic tick1();
        tick_i = 1'b1;
        step();
        tick_i = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d; logic e;
        bus_rd(a, d, e);
        chk(req, d, exp);
    endtask

    task automatic t_reset();
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 rst_req", 32'(rst_req_o), 0);
        chk("R1 err", 32'(err_o), 0);
        for (int i = 0; i < 8; i++) rd_chk("R1 reg", 8'(4 * i), 0);
    endtask

    task automatic t_counter();
        bus_wr(8'h10, 32'd100);
        rd_chk("R3 load", 8'h10, 32'd100);
        repeat (5) tick1();
        rd_chk("R2 five ticks", 8'h10, 32'd105);
        step(); step();
        rd_chk("R2 hold", 8'h10, 32'd105);
        bus_wr(8'h10, 32'hFFFF_FFFF);
        tick1();
        rd_chk("R2 wrap", 8'h10, 32'd0);
        tick_i = 1'b1;
        bus_wr(8'h10, 32'd77);
        tick_i = 1'b0;
        rd_chk("R3 load beats tick", 8'h10, 32'd77);
    endtask

    task automatic t_load_nohit();
        bus_wr(8'h1C, 32'h1);
        bus_wr(8'h00, 32'd50);
        bus_wr(8'h10, 32'd50);
        step(); step();
        chk("R3 load no hit", 32'(irq_o[0]), 0);
    endtask

    task automatic t_match();
        bus_wr(8'h1C, 32'h3);
        bus_wr(8'h04, 32'd10);
        bus_wr(8'h10, 32'd8);
        tick1();
        tick1();
        chk("R4 not early", 32'(irq_o[1]), 0);
        step();
        chk("R4 irq1 up", 32'(irq_o[1]), 1);
        rd_chk("R4 event reg", 8'h14, 32'h2);
    endtask

    task automatic t_masked();
        bus_wr(8'h08, 32'd20);
        bus_wr(8'h10, 32'd19);
        tick1();
        step(); step();
        chk("R5 masked irq2", 32'(irq_o[2]), 0);
        bus_wr(8'h1C, 32'h7);
        step();
        chk("R5 late enable irq2", 32'(irq_o[2]), 0);
        rd_chk("R5 event reg", 8'h14, 32'h2);
    endtask

    task automatic t_w1c();
        bus_wr(8'h14, 32'h0);
        chk("R6 zero write keeps", 32'(irq_o[1]), 1);
        bus_wr(8'h14, 32'h2);
        chk("R6 clear irq1", 32'(irq_o[1]), 0);
        bus_wr(8'h00, 32'd30);
        bus_wr(8'h10, 32'd29);
        tick1();
        bus_wr(8'h14, 32'h1);
        chk("R6 hit beats clear", 32'(irq_o[0]), 1);
        bus_wr(8'h14, 32'h1);
        chk("R6 clear irq0", 32'(irq_o[0]), 0);
    endtask

    task automatic t_mask_width();
        bus_wr(8'h1C, 32'hFFFF_FFFF);
        rd_chk("R7 mask width", 8'h1C, 32'h0000_0FFF);
    endtask

    task automatic t_wdog_fire();
        bus_wr(8'h1C, 32'h0);
        bus_wr(8'h18, 32'h3);
        rd_chk("R8 arm bit only", 8'h18, 32'h1);
        bus_wr(8'h0C, 32'd200);
        bus_wr(8'h10, 32'd199);
        tick1();
        chk("R8 not early", 32'(rst_req_o), 0);
        step();
        chk("R8 request", 32'(rst_req_o), 1);
        step();
        chk("R8 one cycle", 32'(rst_req_o), 0);
        rd_chk("R8 disarmed", 8'h18, 32'h0);
        chk("R8 irq3 masked", 32'(irq_o[3]), 0);
    endtask

    task automatic t_wdog_off();
        bus_wr(8'h1C, 32'h8);
        bus_wr(8'h10, 32'd199);
        tick1();
        step();
        chk("R9 irq3 up", 32'(irq_o[3]), 1);
        chk("R9 no request", 32'(rst_req_o), 0);
        step();
        chk("R9 no request later", 32'(rst_req_o), 0);
    endtask

    task automatic t_readback();
        bus_wr(8'h08, 32'hDEAD_BEEF);
        rd_chk("R10 compare2", 8'h08, 32'hDEAD_BEEF);
        bus_wr(8'h10, 32'h1234);
        rd_chk("R10 counter", 8'h10, 32'h1234);
    endtask

    task automatic t_badaddr();
        logic [31:0] d; logic e;
        bus_rd(8'h24, d, e);
        chk("R11 data", d, 0);
        chk("R11 err", 32'(e), 1);
        step();
        chk("R11 err pulse", 32'(err_o), 0);
        bus_wr(8'h20, 32'h5555_5555);
        rd_chk("R11 counter kept", 8'h10, 32'h1234);
        rd_chk("R11 mask kept", 8'h1C, 32'h8);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_counter();
        t_load_nohit();
        t_match();
        t_masked();
        t_w1c();
        t_mask_width();
        t_wdog_fire();
        t_wdog_off();
        t_readback();
        t_badaddr();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule